// File: doc/BRIEF.md
# Resync Cell State-Vector Processor

This block services the cryptographic resynchronization cells of a multi-connection cell encryptor. Every connection owns a state vector in an external state memory. The vector holds a jump count, a role bit, a sequence count, a segment count and a keystream register value. A command names a connection and one of two operations.

An **insert** command advances the connection's jump count and resets the rest of its vector. It writes the result back to memory and produces an outgoing resync payload. That payload is the new vector followed by a 10-bit CRC.

A **receive** command checks an incoming resync payload in two ways. Its CRC must be correct, and its jump count must be strictly larger than the stored one. Only if both hold does the block install a freshly reset vector that carries the received jump count. Otherwise the stored vector is left as it was.

Each command takes two clock cycles, far less than a cell period. The block reports the outcome with a one-cycle `done` pulse and the flags `ok` and `sat_err`.

Top module: `resync_sv_proc`

## Requirements
- R1: After reset, `done`, `ok`, `sat_err`, `cell_valid` and `mem_we` are 0, and `cmd_ready` is 1.
- R2: Insert with a stored jump count below 255 writes to the addressed connection a vector made of these fields: jump count + 1 in bits [47:40]; role bit [39] equal to `role_init`; sequence [38:27] = 0; segment [26:23] = 0; keystream register [22:0] = 23'h5A5A5A. It then reports `ok` = 1.
- R3: The outgoing payload is {vector[47:0], crc[9:0]}. The CRC is computed over the 48 vector bits, most significant bit first, with a zero start value and the generator x^10+x^9+x^5+x^4+x+1.
- R4: Insert with a stored jump count of 255 writes nothing and emits no cell. It reports `ok` = 0 and `sat_err` = 1.
- R5: A receive payload that has a correct CRC and a jump count strictly above the stored one is accepted. The block writes {received jump count, received role bit, 12'h0, 4'h0, 23'h5A5A5A} and reports `ok` = 1.
- R6: A receive payload with a wrong CRC writes nothing and reports `ok` = 0. A later insert on that connection shows the old jump count + 1.
- R7: A receive payload whose jump count is equal to or below the stored one writes nothing and reports `ok` = 0.
- R8: A command accepted at one clock edge raises `done` for exactly one cycle after the second following edge. `cmd_ready` is 0 in between.
- R9: Every memory read and write of a command uses that command's connection number. No other connection's vector changes.
- R10: `cell_valid` pulses, together with `done` and `ok`, only for a successful insert. It never pulses for a receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| role_init | input | 1 | 1 when this end is the initiator; copied to the role bit on insert |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_rx | input | 1 | 1 = receive command, 0 = insert command |
| cmd_conn | input | 4 | Connection number |
| cmd_payload | input | 58 | Received resync payload (receive only) |
| mem_rd_en | output | 1 | State memory read strobe; data expected one cycle later |
| mem_addr | output | 4 | State memory address for read and write |
| mem_rdata | input | 48 | State memory read data |
| mem_we | output | 1 | State memory write strobe |
| mem_wdata | output | 48 | State memory write data |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | With done: the vector was updated |
| sat_err | output | 1 | With done: insert refused, jump count at maximum |
| cell_valid | output | 1 | Outgoing resync payload present |
| cell_payload | output | 58 | Outgoing resync payload |

## Verification
The assertions assume that the state memory returns, one cycle after `mem_rd_en`, the last value written to the same address. They also assume that `cmd_valid` is raised only between commands. The bench meets both conditions. Its memory model reads and writes synchronously, and it issues each command only after the previous `done` has been seen. The assertions comparing written and read jump counts depend on that read-after-write ordering. The stimulus therefore never overlaps a read with a pending write to the same connection.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int JN_W    = 8;
  localparam int SEQ_W   = 12;
  localparam int SEG_W   = 4;
  localparam int LFSR_W  = 23;
  localparam int CRC_W   = 10;
  localparam int SV_W    = JN_W + 1 + SEQ_W + SEG_W + LFSR_W;
  localparam int PAY_W   = SV_W + CRC_W;
  localparam logic [LFSR_W-1:0] LFSR_PRESET = 23'h5A5A5A;
  localparam logic [CRC_W-1:0]  CRC_POLY    = 10'h233;

  typedef struct packed {
    logic [JN_W-1:0]   jn;
    logic              ir;
    logic [SEQ_W-1:0]  seq;
    logic [SEG_W-1:0]  seg;
    logic [LFSR_W-1:0] lfsr;
  } sv_t;

  typedef enum logic {ST_IDLE, ST_EVAL} st_t;

  // Serial CRC, MSB first, zero start value.
  function automatic logic [CRC_W-1:0] crc10(input logic [SV_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = SV_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  // Vector after a resync: given jump count and role, everything else reset.
  function automatic sv_t sv_fresh(input logic [JN_W-1:0] jn, input logic ir);
    sv_t s;
    s.jn   = jn;
    s.ir   = ir;
    s.seq  = '0;
    s.seg  = '0;
    s.lfsr = LFSR_PRESET;
    return s;
  endfunction
endpackage

// File: rtl/rsv_insert_step.sv
module rsv_insert_step
  import rsv_pkg::*;
(
  input  sv_t              cur,
  input  logic             role,
  output sv_t              nxt,
  output logic             sat,
  output logic [PAY_W-1:0] payload
);
  assign sat     = &cur.jn;
  assign nxt     = sv_fresh(cur.jn + 1'b1, role);
  assign payload = {nxt, crc10(nxt)};
endmodule

// File: rtl/rsv_rx_check.sv
module rsv_rx_check
  import rsv_pkg::*;
(
  input  logic [PAY_W-1:0] payload,
  input  sv_t              cur,
  output logic             crc_good,
  output logic             jn_newer,
  output logic             accept,
  output sv_t              nxt
);
  sv_t rx_sv;
  assign rx_sv    = sv_t'(payload[PAY_W-1:CRC_W]);
  assign crc_good = (crc10(rx_sv) == payload[CRC_W-1:0]);
  assign jn_newer = (rx_sv.jn > cur.jn);
  assign accept   = crc_good && jn_newer;
  assign nxt      = sv_fresh(rx_sv.jn, rx_sv.ir);
endmodule

// File: rtl/resync_sv_proc.sv
module resync_sv_proc
  import rsv_pkg::*;
#(
  parameter int NUM_CONN = 16,
  localparam int CONN_W  = $clog2(NUM_CONN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_init,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_rx,
  input  logic [CONN_W-1:0] cmd_conn,
  input  logic [PAY_W-1:0]  cmd_payload,
  output logic              mem_rd_en,
  output logic [CONN_W-1:0] mem_addr,
  input  logic [SV_W-1:0]   mem_rdata,
  output logic              mem_we,
  output logic [SV_W-1:0]   mem_wdata,
  output logic              done,
  output logic              ok,
  output logic              sat_err,
  output logic              cell_valid,
  output logic [PAY_W-1:0]  cell_payload
);
  st_t               state;
  logic              rx_q;
  logic [CONN_W-1:0] conn_q;
  logic [PAY_W-1:0]  pay_q;

  // Named internal events
  logic cmd_fire, in_eval, ins_commit, rx_commit, commit;
  sv_t  stored, ins_nxt, rx_nxt, wd_s;
  logic ins_sat, rx_crc_good, rx_jn_newer, rx_accept;
  logic [PAY_W-1:0] ins_payload;

  assign cmd_ready = (state == ST_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign in_eval   = (state == ST_EVAL);
  assign stored    = sv_t'(mem_rdata);

  rsv_insert_step u_ins (
    .cur(stored), .role(role_init), .nxt(ins_nxt),
    .sat(ins_sat), .payload(ins_payload)
  );

  rsv_rx_check u_rx (
    .payload(pay_q), .cur(stored), .crc_good(rx_crc_good),
    .jn_newer(rx_jn_newer), .accept(rx_accept), .nxt(rx_nxt)
  );

  assign ins_commit = in_eval && !rx_q && !ins_sat;
  assign rx_commit  = in_eval && rx_q && rx_accept;
  assign commit     = ins_commit || rx_commit;

  assign mem_rd_en = cmd_fire;
  assign mem_addr  = in_eval ? conn_q : cmd_conn;
  assign mem_we    = commit;
  assign wd_s      = rx_q ? rx_nxt : ins_nxt;
  assign mem_wdata = wd_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      rx_q         <= 1'b0;
      conn_q       <= '0;
      pay_q        <= '0;
      done         <= 1'b0;
      ok           <= 1'b0;
      sat_err      <= 1'b0;
      cell_valid   <= 1'b0;
      cell_payload <= '0;
    end else begin
      done       <= 1'b0;
      ok         <= 1'b0;
      sat_err    <= 1'b0;
      cell_valid <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_fire) begin
          rx_q   <= cmd_rx;
          conn_q <= cmd_conn;
          pay_q  <= cmd_payload;
          state  <= ST_EVAL;
        end
        ST_EVAL: begin
          done       <= 1'b1;
          ok         <= commit;
          sat_err    <= !rx_q && ins_sat;
          cell_valid <= ins_commit;
          if (ins_commit) cell_payload <= ins_payload;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Assertions
  assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> ##2 done);
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_ready);
  assert_write_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (done && ok));
  assert_sat_no_cell_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sat_err) |-> (!ok && !cell_valid));
  assert_rx_newer_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && rx_q) |-> (wd_s.jn > stored.jn));
  assert_ins_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !rx_q) |-> (wd_s.jn == stored.jn + 1'b1));
  assert_cell_crc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> (crc10(cell_payload[PAY_W-1:CRC_W]) == cell_payload[CRC_W-1:0]));
  assert_cell_only_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> (done && ok && !sat_err));
endmodule

// File: tb/tb_resync_sv_proc.sv
`timescale 1ns/1ps
module tb_resync_sv_proc;
  localparam logic [22:0] PRESET = 23'h5A5A5A;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, role_init, cmd_valid, cmd_ready, cmd_rx;
  logic [3:0]  cmd_conn, mem_addr;
  logic [57:0] cmd_payload, cell_payload;
  logic        mem_rd_en, mem_we, done, ok, sat_err, cell_valid;
  logic [47:0] mem_rdata, mem_wdata;

  resync_sv_proc dut (
    .clk(clk), .rst_n(rst_n), .role_init(role_init),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rx(cmd_rx),
    .cmd_conn(cmd_conn), .cmd_payload(cmd_payload),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .done(done), .ok(ok),
    .sat_err(sat_err), .cell_valid(cell_valid), .cell_payload(cell_payload)
  );

  // State memory model, synchronous read
  logic [47:0] mem [16];
  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  int checks = 0;
  int errors = 0;
  logic [47:0] model [16];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // CRC by polynomial long division of {data, 10 zeros}
  function automatic logic [9:0] bcrc(input logic [47:0] d);
    logic [57:0] m;
    m = {d, 10'b0};
    for (int i = 57; i >= 10; i--)
      if (m[i]) m[i -: 11] = m[i -: 11] ^ 11'h633;
    return m[9:0];
  endfunction

  task automatic run_cmd(input logic rx, input logic [3:0] c, input logic [7:0] jn,
                         input logic bad, input logic ir);
    logic [47:0] cur, exp_sv, rx_sv;
    logic exp_ok, exp_sat, we_s, done_mid;
    logic [47:0] wd_s;
    logic [3:0]  wa_s;
    string tag;
    cur = model[c];
    rx_sv = {jn, ir, 12'hABC, 4'h7, 23'h12345};
    exp_sat = 1'b0;
    if (!rx) begin
      exp_sat = (cur[47:40] == 8'hFF);
      exp_ok  = !exp_sat;
      exp_sv  = {cur[47:40] + 8'd1, role_init, 12'd0, 4'd0, PRESET};
      tag = exp_sat ? "R4" : "R2";
    end else begin
      exp_ok = !bad && (jn > cur[47:40]);
      exp_sv = {jn, ir, 12'd0, 4'd0, PRESET};
      tag = bad ? "R6" : (exp_ok ? "R5" : "R7");
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rx = rx; cmd_conn = c;
    cmd_payload = {rx_sv, bcrc(rx_sv) ^ {9'd0, bad}};
    @(negedge clk);
    cmd_valid = 1'b0;
    we_s = mem_we; wd_s = mem_wdata; wa_s = mem_addr; done_mid = done;
    chk("R8", {63'd0, cmd_ready}, 64'd0);
    chk("R8", {63'd0, done_mid}, 64'd0);
    @(negedge clk);
    chk("R8", {63'd0, done}, 64'd1);
    chk(tag, {63'd0, ok}, {63'd0, exp_ok});
    chk(tag, {63'd0, sat_err}, {63'd0, exp_sat});
    chk(tag, {63'd0, we_s}, {63'd0, exp_ok});
    if (exp_ok) begin
      chk(tag, {16'd0, wd_s}, {16'd0, exp_sv});
      chk("R9", {60'd0, wa_s}, {60'd0, c});
      model[c] = exp_sv;
    end
    chk("R10", {63'd0, cell_valid}, {63'd0, !rx && exp_ok});
    if (!rx && exp_ok)
      chk("R3", {6'd0, cell_payload}, {6'd0, exp_sv, bcrc(exp_sv)});
  endtask

  // {rx, conn[3:0], jn[7:0], bad_crc, ir}
  localparam logic [14:0] VEC [15] = '{
    {1'b0, 4'd0, 8'd0,   1'b0, 1'b0},  // insert c0 -> 1
    {1'b0, 4'd0, 8'd0,   1'b0, 1'b0},  // insert c0 -> 2
    {1'b0, 4'd3, 8'd0,   1'b0, 1'b0},  // insert c3 -> 1
    {1'b1, 4'd0, 8'd5,   1'b0, 1'b1},  // receive newer, accepted
    {1'b0, 4'd0, 8'd0,   1'b0, 1'b0},  // insert c0 -> 6
    {1'b1, 4'd0, 8'd6,   1'b0, 1'b0},  // equal jump, ignored
    {1'b1, 4'd0, 8'd9,   1'b1, 1'b0},  // bad CRC, ignored
    {1'b0, 4'd0, 8'd0,   1'b0, 1'b0},  // insert c0 -> 7 shows no change
    {1'b1, 4'd3, 8'd2,   1'b0, 1'b1},  // c3 accepted
    {1'b1, 4'd3, 8'd255, 1'b0, 1'b0},  // c3 to max
    {1'b0, 4'd3, 8'd0,   1'b0, 1'b0},  // saturated
    {1'b0, 4'd3, 8'd0,   1'b0, 1'b0},  // saturated again
    {1'b1, 4'd5, 8'd0,   1'b0, 1'b0},  // 0 not above 0, ignored
    {1'b0, 4'd5, 8'd0,   1'b0, 1'b0},  // c5 untouched -> 1
    {1'b1, 4'd3, 8'd255, 1'b0, 1'b1}   // not above 255, ignored
  };

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = '0; model[i] = '0; end
    rst_n = 1'b0; role_init = 1'b1; cmd_valid = 1'b0; cmd_rx = 1'b0;
    cmd_conn = '0; cmd_payload = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk("R1", {63'd0, done}, 64'd0);
    chk("R1", {63'd0, cell_valid}, 64'd0);
    chk("R1", {63'd0, ok | sat_err}, 64'd0);
    chk("R1", {63'd0, mem_we}, 64'd0);
    chk("R1", {63'd0, cmd_ready}, 64'd1);

    for (int v = 0; v < 15; v++)
      run_cmd(VEC[v][14], VEC[v][13:10], VEC[v][9:2], VEC[v][1], VEC[v][0]);

    // R2: responder role sets the role bit to 0
    role_init = 1'b0;
    run_cmd(1'b0, 4'd7, 8'd0, 1'b0, 1'b0);
    // R9: earlier connections keep their vectors
    run_cmd(1'b0, 4'd0, 8'd0, 1'b0, 1'b0);
    run_cmd(1'b0, 4'd5, 8'd0, 1'b0, 1'b0);

    // R8: done is a single-cycle pulse
    @(negedge clk);
    chk("R8", {63'd0, done}, 64'd0);
    chk("R1", {63'd0, cmd_ready}, 64'd1);

    summary();
    $finish;
  end
endmodule